// File: doc/BRIEF.md
# DRAM Strobe Cycle Classifier with Refresh Row Counter

This block sits on the device side of an asynchronous DRAM interface. It samples the active-low row strobe, column strobe and write-enable pins with a fast system clock. From the order in which the strobe edges arrive it works out what each row cycle is. The possible kinds are an ordinary access, a refresh of an externally supplied row, a refresh with CAS before RAS, a hidden refresh, a self refresh and an entry into parallel test mode.

For every refresh the block emits a one-clock pulse together with the row that the array must refresh. An internal 10-bit row counter supplies the row for the internal refresh kinds. The row pins supply it for the externally addressed kind. Two level outputs report that self refresh is running and that the device is in test mode. All outputs are registered: a strobe sample taken at clock edge k shows up on the outputs just after edge k.

Kind codes on `cycle_o`: 0 idle (since reset), 1 normal access, 2 RAS-only refresh, 3 CBR refresh, 4 hidden refresh, 5 self refresh, 6 test-mode entry. A RAS fall is a sample with `ras_ni`=0 that follows a sample with `ras_ni`=1.

Top module: `dram_cycle_decoder`

## Requirements
- R1: After reset `cycle_o` is 0, `ref_pulse_o`, `self_ref_o` and `test_mode_o` are 0, and the internal row counter holds 0, so the first internal refresh reports row 0.
- R2: A RAS fall sampled with `cas_ni`=0 and `we_ni`=1, where CAS was not held over from an access, sets `cycle_o` to 3. It gives a one-clock `ref_pulse_o` with `ref_row_o` equal to the internal counter, and it clears `test_mode_o`. `row_addr_i` has no effect on the reported row.
- R3: The internal counter advances by one after every CBR, hidden and self-refresh row, and only then. It wraps from 1023 to 0.
- R4: A RAS fall sampled with `cas_ni`=1, with CAS high in every sample until the first sample with `ras_ni`=1, is a RAS-only refresh. At that rising sample `cycle_o` becomes 2 and `ref_pulse_o` pulses with `ref_row_o` equal to `row_addr_i` as sampled at the fall. `test_mode_o` clears and the internal counter does not move.
- R5: If the row opened with CAS high and CAS is sampled low at any point up to and including the RAS rising sample, `cycle_o` becomes 1 at the rise and no refresh pulse is produced.
- R6: If CAS was sampled low during an open access and stays low through the following RAS fall, that fall is a hidden refresh. `cycle_o` becomes 4 and there is a pulse with the internal counter row. Each further RAS cycle with CAS still held low is another hidden refresh.
- R7: A CBR-type fall with `we_ni`=0 sets `cycle_o` to 6 and `test_mode_o` to 1, with no refresh pulse and no counter change. Test mode survives normal and hidden cycles and is left only by an R2 or R4 cycle.
- R8: If RAS stays low for SELF_TH_CYC clocks after a CBR fall (R2 only), `self_ref_o` rises, `cycle_o` becomes 5 and an internal refresh row is issued in that same clock.
- R9: While self refresh runs, an internal refresh pulse is issued every SELF_INT_CYC clocks. The first sample with `ras_ni`=1 clears `self_ref_o` at once, and no further pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| row_addr_i | input | 10 | Row address pins |
| cycle_o | output | 3 | Kind of the last classified cycle |
| ref_pulse_o | output | 1 | One-clock refresh request |
| ref_row_o | output | 10 | Row to refresh, valid with the pulse |
| self_ref_o | output | 1 | Self refresh running |
| test_mode_o | output | 1 | Parallel test mode active |

## Verification
The hardest states to reach are hidden refresh and the counter wrap. Hidden refresh depends on CAS history that spans two RAS cycles: the stimulus opens a row with CAS high, drops CAS, raises RAS while keeping CAS low, and then drops RAS again twice. The wrap needs more than a thousand internal refreshes, so the bench runs a long train of short CBR cycles and checks that every reported row is one past the previous. Self refresh uses shortened threshold and interval parameters, so that entry, several periodic rows and exit all fit in a short run.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
  typedef enum logic [2:0] {
    CY_IDLE     = 3'd0,
    CY_NORMAL   = 3'd1,
    CY_RAS_ONLY = 3'd2,
    CY_CBR      = 3'd3,
    CY_HIDDEN   = 3'd4,
    CY_SELF     = 3'd5,
    CY_TEST     = 3'd6
  } cycle_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ROW,
    PH_CBR,
    PH_SELF,
    PH_OTHER
  } phase_e;
endpackage

// File: rtl/dcd_refresh_ctr.sv
module dcd_refresh_ctr #(
  parameter int ROW_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [ROW_W-1:0] row_o
);
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    row_q <= '0;
    else if (inc_i) row_q <= row_q + ROW_W'(1);
  end

  assign row_o = row_q;

  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |=> row_o == $past(row_o) + ROW_W'(1));
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(row_o));
endmodule

// File: rtl/dcd_low_timer.sv
module dcd_low_timer #(
  parameter int SELF_TH_CYC  = 10000,
  parameter int SELF_INT_CYC = 1560
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic cbr_i,
  input  logic self_i,
  output logic enter_o,
  output logic tick_o
);
  localparam int MAXV = (SELF_TH_CYC > SELF_INT_CYC) ? SELF_TH_CYC : SELF_INT_CYC;
  localparam int CW   = $clog2(MAXV + 1);

  logic [CW-1:0] cnt_q;

  assign enter_o = cbr_i  && (cnt_q == CW'(SELF_TH_CYC - 1));
  assign tick_o  = self_i && (cnt_q == CW'(SELF_INT_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             cnt_q <= '0;
    else if (clr_i || enter_o || tick_o)     cnt_q <= '0;
    else if (cbr_i || self_i)                cnt_q <= cnt_q + CW'(1);
  end

  initial begin
    p_params_r8: assert (SELF_TH_CYC >= 2 && SELF_INT_CYC >= 2);
  end
endmodule

// File: rtl/dcd_cycle_fsm.sv
module dcd_cycle_fsm
  import dcd_pkg::*;
#(
  parameter int ROW_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ras_ni,
  input  logic             cas_ni,
  input  logic             we_ni,
  input  logic [ROW_W-1:0] row_addr_i,
  input  logic [ROW_W-1:0] ctr_row_i,
  input  logic             enter_i,
  input  logic             tick_i,
  output logic             clr_o,
  output logic             cbr_o,
  output logic             self_o,
  output logic             inc_o,
  output logic [2:0]       cycle_o,
  output logic             ref_pulse_o,
  output logic [ROW_W-1:0] ref_row_o,
  output logic             self_ref_o,
  output logic             test_mode_o
);
  phase_e           phase_q;
  cycle_e           cycle_q;
  logic             ras_q, acc_q, hold_q;
  logic [ROW_W-1:0] row_q;
  logic             ras_fall, cbr_fall, hid_fall, hold_d;

  assign ras_fall = ras_q && !ras_ni;
  assign hid_fall = ras_fall && !cas_ni && hold_q;
  assign cbr_fall = ras_fall && !cas_ni && !hold_q && we_ni;
  // CAS held low since it dropped inside an open access row
  assign hold_d   = !cas_ni && (hold_q || (phase_q == PH_ROW && !ras_ni));

  assign clr_o  = ras_fall;
  assign cbr_o  = (phase_q == PH_CBR)  && !ras_ni;
  assign self_o = (phase_q == PH_SELF) && !ras_ni;
  assign inc_o  = cbr_fall || hid_fall || enter_i || tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_IDLE;
      cycle_q     <= CY_IDLE;
      ras_q       <= 1'b1;
      acc_q       <= 1'b0;
      hold_q      <= 1'b0;
      row_q       <= '0;
      ref_pulse_o <= 1'b0;
      ref_row_o   <= '0;
      self_ref_o  <= 1'b0;
      test_mode_o <= 1'b0;
    end else begin
      ras_q       <= ras_ni;
      hold_q      <= hold_d;
      ref_pulse_o <= 1'b0;
      if (ras_fall) begin
        row_q <= row_addr_i;
        acc_q <= 1'b0;
        if (cas_ni) begin
          phase_q <= PH_ROW;
        end else if (hold_q) begin
          phase_q     <= PH_OTHER;
          cycle_q     <= CY_HIDDEN;
          ref_pulse_o <= 1'b1;
          ref_row_o   <= ctr_row_i;
        end else if (!we_ni) begin
          phase_q     <= PH_OTHER;
          cycle_q     <= CY_TEST;
          test_mode_o <= 1'b1;
        end else begin
          phase_q     <= PH_CBR;
          cycle_q     <= CY_CBR;
          ref_pulse_o <= 1'b1;
          ref_row_o   <= ctr_row_i;
          test_mode_o <= 1'b0;
        end
      end else if (phase_q != PH_IDLE && ras_ni) begin
        phase_q    <= PH_IDLE;
        self_ref_o <= 1'b0;
        if (phase_q == PH_ROW) begin
          if (acc_q || !cas_ni) begin
            cycle_q <= CY_NORMAL;
          end else begin
            cycle_q     <= CY_RAS_ONLY;
            ref_pulse_o <= 1'b1;
            ref_row_o   <= row_q;
            test_mode_o <= 1'b0;
          end
        end
      end else begin
        if (phase_q == PH_ROW && !cas_ni) acc_q <= 1'b1;
        if (enter_i) begin
          phase_q     <= PH_SELF;
          cycle_q     <= CY_SELF;
          self_ref_o  <= 1'b1;
          ref_pulse_o <= 1'b1;
          ref_row_o   <= ctr_row_i;
        end else if (tick_i) begin
          ref_pulse_o <= 1'b1;
          ref_row_o   <= ctr_row_i;
        end
      end
    end
  end

  assign cycle_o = cycle_q;

  p_test_entry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(test_mode_o) |-> $past(!ras_ni && !cas_ni && !we_ni));
  p_self_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(self_ref_o) |-> $past(!ras_ni));
  p_self_exit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (self_ref_o && ras_ni) |=> !self_ref_o);
  p_self_no_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (self_ref_o && ras_ni) |=> !ref_pulse_o);
endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder #(
  parameter int ROW_W        = 10,
  parameter int SELF_TH_CYC  = 10000,
  parameter int SELF_INT_CYC = 1560
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ras_ni,
  input  logic             cas_ni,
  input  logic             we_ni,
  input  logic [ROW_W-1:0] row_addr_i,
  output logic [2:0]       cycle_o,
  output logic             ref_pulse_o,
  output logic [ROW_W-1:0] ref_row_o,
  output logic             self_ref_o,
  output logic             test_mode_o
);
  logic             clr, cbr_run, self_run, inc, enter, tick;
  logic [ROW_W-1:0] ctr_row;

  dcd_refresh_ctr #(.ROW_W(ROW_W)) u_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (inc),
    .row_o (ctr_row)
  );

  dcd_low_timer #(.SELF_TH_CYC(SELF_TH_CYC), .SELF_INT_CYC(SELF_INT_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .cbr_i  (cbr_run),
    .self_i (self_run),
    .enter_o(enter),
    .tick_o (tick)
  );

  dcd_cycle_fsm #(.ROW_W(ROW_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ras_ni     (ras_ni),
    .cas_ni     (cas_ni),
    .we_ni      (we_ni),
    .row_addr_i (row_addr_i),
    .ctr_row_i  (ctr_row),
    .enter_i    (enter),
    .tick_i     (tick),
    .clr_o      (clr),
    .cbr_o      (cbr_run),
    .self_o     (self_run),
    .inc_o      (inc),
    .cycle_o    (cycle_o),
    .ref_pulse_o(ref_pulse_o),
    .ref_row_o  (ref_row_o),
    .self_ref_o (self_ref_o),
    .test_mode_o(test_mode_o)
  );
endmodule

// File: tb/dram_cycle_decoder_bench.sv
`timescale 1ns/1ps
module dram_cycle_decoder_bench;
  localparam int TH  = 40;
  localparam int INT = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ras = 1'b1, cas = 1'b1, we = 1'b1;
  logic [9:0] addr = '0;
  logic [2:0] cyc;
  logic       pulse, selfr, tmode;
  logic [9:0] prow;

  int checks = 0, fails = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  dram_cycle_decoder #(.ROW_W(10), .SELF_TH_CYC(TH), .SELF_INT_CYC(INT)) u_dram_cycle_decoder (
    .clk_i(clk), .rst_ni(rst_n), .ras_ni(ras), .cas_ni(cas), .we_ni(we),
    .row_addr_i(addr), .cycle_o(cyc), .ref_pulse_o(pulse), .ref_row_o(prow),
    .self_ref_o(selfr), .test_mode_o(tmode)
  );

  // behavioural reference: phase 0 idle, 1 open row, 2 cbr low, 3 self, 4 other
  int  m_phase, m_low, m_cnt, m_cap;
  bit  m_prev_ras, m_acc, m_hold, nh;
  int  e_type, e_row;
  bit  e_pulse, e_self, e_test;

  task automatic emit();
    e_pulse = 1; e_row = m_cnt; m_cnt = (m_cnt + 1) % 1024;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_low = 0; m_cnt = 0; m_cap = 0; m_prev_ras = 1; m_acc = 0; m_hold = 0;
      e_type = 0; e_row = 0; e_pulse = 0; e_self = 0; e_test = 0;
    end else begin
      e_pulse = 0;
      nh = !cas && (m_hold || (m_phase == 1 && !ras));
      if (m_prev_ras && !ras) begin
        m_cap = addr; m_acc = 0; m_low = 0;
        if (cas) m_phase = 1;
        else if (m_hold) begin m_phase = 4; e_type = 4; emit(); end
        else if (!we) begin m_phase = 4; e_type = 6; e_test = 1; end
        else begin m_phase = 2; e_type = 3; emit(); e_test = 0; end
      end else if (m_phase != 0 && ras) begin
        if (m_phase == 1) begin
          if (m_acc || !cas) e_type = 1;
          else begin e_type = 2; e_pulse = 1; e_row = m_cap; e_test = 0; end
        end
        m_phase = 0; e_self = 0;
      end else begin
        if (m_phase == 1 && !cas) m_acc = 1;
        if (m_phase == 2) begin
          if (m_low == TH - 1) begin m_phase = 3; e_self = 1; e_type = 5; emit(); m_low = 0; end
          else m_low++;
        end else if (m_phase == 3) begin
          if (m_low == INT - 1) begin emit(); m_low = 0; end
          else m_low++;
        end
      end
      m_hold = nh; m_prev_ras = ras;
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d @%0t", tag, what, act, exp, $time);
    end
  endtask

  // per-clock comparison, away from the active edge
  int last_row = -1;
  int pulse_cnt = 0;
  always @(negedge clk) if (rst_n) begin
    chk(cur_req, "cycle", cyc, e_type);
    chk(cur_req, "pulse", pulse, e_pulse);
    chk(cur_req, "self", selfr, e_self);
    chk(cur_req, "test", tmode, e_test);
    if (e_pulse) chk(cur_req, "row", prow, e_row);
    if (pulse) begin last_row = prow; pulse_cnt++; end
  end

  task automatic drv(bit r, bit c, bit w, logic [9:0] a, int n);
    @(negedge clk);
    ras = r; cas = c; we = w; addr = a;
    repeat (n) @(posedge clk);
  endtask

  task automatic cbr(logic [9:0] a);
    drv(1, 0, 1, a, 1);
    drv(0, 0, 1, ~a, 3);
    drv(1, 1, 1, a, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset state
    cur_req = "R1";
    drv(1, 1, 1, 10'h155, 4);
    @(negedge clk);
    chk("R1", "reset cycle", cyc, 0);
    chk("R1", "reset test", tmode, 0);

    // R2: CBR with varied address pins, R3 increments
    cur_req = "R2";
    cbr(10'h3FF); cbr(10'h001); cbr(10'h2AA);
    @(negedge clk);
    chk("R2", "third cbr row", last_row, 2);

    // R4: RAS-only refresh of an external row
    cur_req = "R4";
    drv(0, 1, 1, 10'h2A5, 4);
    drv(1, 1, 1, 10'h000, 3);
    @(negedge clk);
    chk("R4", "ras-only row", last_row, 10'h2A5);
    chk("R4", "ras-only cycle", cyc, 2);

    // R5: normal access, CAS drop and release inside the row
    cur_req = "R5";
    drv(0, 1, 1, 10'h011, 2);
    drv(0, 0, 0, 10'h022, 2);
    drv(0, 1, 1, 10'h022, 1);
    drv(1, 1, 1, 10'h022, 3);
    @(negedge clk);
    chk("R5", "normal cycle", cyc, 1);

    // R6: access, CAS held low across two further RAS cycles
    cur_req = "R6";
    drv(0, 1, 1, 10'h0F0, 2);
    drv(0, 0, 1, 10'h0F0, 2);
    drv(1, 0, 1, 10'h0F0, 2);
    drv(0, 0, 1, 10'h0F0, 3);
    @(negedge clk);
    chk("R6", "hidden cycle", cyc, 4);
    drv(1, 0, 1, 10'h0F0, 2);
    drv(0, 0, 0, 10'h0F0, 3);
    drv(1, 1, 1, 10'h0F0, 3);

    // R7: test entry, survives access and hidden, left by RAS-only and by CBR
    cur_req = "R7";
    drv(1, 0, 0, 10'h000, 1);
    drv(0, 0, 0, 10'h000, 3);
    drv(1, 1, 1, 10'h000, 2);
    @(negedge clk);
    chk("R7", "test flag set", tmode, 1);
    chk("R7", "test cycle", cyc, 6);
    drv(0, 1, 1, 10'h033, 2); drv(0, 0, 1, 10'h033, 2); drv(1, 0, 1, 10'h033, 2);
    drv(0, 0, 1, 10'h033, 3); drv(1, 1, 1, 10'h033, 3);
    @(negedge clk);
    chk("R7", "test kept after hidden", tmode, 1);
    drv(0, 1, 1, 10'h044, 3); drv(1, 1, 1, 10'h044, 3);
    @(negedge clk);
    chk("R7", "test left by ras-only", tmode, 0);
    drv(1, 0, 0, 10'h000, 1); drv(0, 0, 0, 10'h000, 3); drv(1, 1, 1, 10'h000, 2);
    cbr(10'h000);
    @(negedge clk);
    chk("R7", "test left by cbr", tmode, 0);

    // R8/R9: self refresh entry, periodic rows, exit
    cur_req = "R8";
    base = pulse_cnt;
    drv(1, 0, 1, 10'h000, 1);
    drv(0, 0, 1, 10'h000, TH + 1);
    @(negedge clk);
    chk("R8", "self flag", selfr, 1);
    cur_req = "R9";
    drv(0, 0, 1, 10'h000, 4 * INT);
    @(negedge clk);
    chk("R9", "self pulses", pulse_cnt - base, 6);
    drv(1, 1, 1, 10'h000, 2);
    @(negedge clk);
    chk("R9", "self exit", selfr, 0);

    // R3: long CBR train across the wrap, each row one past the previous
    cur_req = "R3";
    for (int i = 0; i < 1030; i++) begin
      int prev;
      prev = last_row;
      cbr(10'(i));
      @(negedge clk);
      chk("R3", "row step", last_row, (prev + 1) % 1024);
    end

    drv(1, 1, 1, 10'h000, 3);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule